// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the digital divider chain of a frequency synthesizer. A fast feedback clock is divided by P×N+A. A logic dual-modulus prescaler divides by P or P+1. A swallow counter keeps the prescaler at P+1 for the first A of its output cycles in every period. A main counter counts N prescaler outputs per period. A separate binary counter divides the oscillator clock by R. The two results are single-cycle comparison pulses, `fp_o` and `fr_o`, each in its own clock domain. A phase comparator downstream uses them to steer the loop toward (P×N+A)×fosc/R.

The divide settings arrive as static, already-latched words. Each counter copies them only when it reloads at the end of a period, so a period in progress always finishes with the values it began with. A build-time parameter selects the band. Within that band, a select bit picks one of two prescaler pairs. An active-low power-save input holds every counter at its start state. While it is low, no pulses are issued.

Top module: `pulse_swallow_divider`

## Requirements
- R1: With 3 ≤ N ≤ 2047 and 0 ≤ A ≤ 127, A < N, consecutive `fp_o` pulses are exactly P×N+A `clk_vco_i` cycles apart.
- R2: Base modulus P is 32 when `band_sel_i`=1 and 64 when `band_sel_i`=0 with HIGH_BAND=0. It is 64 when `band_sel_i`=1 and 128 when `band_sel_i`=0 with HIGH_BAND=1.
- R3: The prescaler divides by P+1 for the first A of its output cycles in a period and by P for the other N−A. Its modulus control changes only at a prescaler terminal count, or when a period starts.
- R4: With 3 ≤ R ≤ 16383, consecutive `fr_o` pulses are exactly R `clk_osc_i` cycles apart.
- R5: `fp_o` and `fr_o` are each high for exactly one cycle per period.
- R6: A change of `swallow_i`, `main_i`, `band_sel_i` or `ref_i` during a period does not alter that period. The change applies from the next period.
- R7: Settings present in the last cycle of a period are taken by the reload at the end of that period. The following period uses them.
- R8: While `pwrsave_ni` is low, `fp_o` and `fr_o` stay low and all counters are held. `pwrsave_ni` may then go high before a rising edge. Counting that edge as the first, the first `fp_o` is high after edge P×N+A+1 and the first `fr_o` after edge R+1.
- R9: While `rst_ni` is low, both outputs are low. After release, the first pulses follow the same timing as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | Fast feedback clock (prescaler input) |
| clk_osc_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrsave_ni | input | 1 | Power-save, active low; holds counters at start |
| swallow_i | input | A_W | Swallow count A |
| main_i | input | N_W | Main count N |
| ref_i | input | R_W | Reference divide R |
| band_sel_i | input | 1 | Prescaler pair select within the band |
| fp_o | output | 1 | Feedback comparison pulse, `clk_vco_i` domain |
| fr_o | output | 1 | Reference comparison pulse, `clk_osc_i` domain |

## Verification
The end of a period and a change of settings can fall in the same cycle. The terminal-count reload then competes with the new input words. The bench forces this by timing a change of A and N to land exactly in the last cycle of a period. It expects the next pulse one cycle later and the period after that to match the new P×N+A. A second case changes the settings just after a pulse and expects one further full period at the old value before the new one applies.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PRE_MAX = 129;
  localparam int unsigned PRE_W   = $clog2(PRE_MAX);

  // base modulus: each band step or deselect doubles 32
  function automatic int unsigned base_mod(input bit high_band, input logic sel);
    return 32 << (int'(high_band) + int'(!sel));
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter bit HIGH_BAND = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic sel_i,
  input  logic mod_hi_i,
  output logic tc_o
);
  import psd_pkg::*;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(base_mod(HIGH_BAND, 1'b1) - 1);
  logic [PRE_W-1:0] limit_lo;
  assign limit_lo = PRE_W'(base_mod(HIGH_BAND, 1'b0) - 1);

  logic [PRE_W-1:0] last;
  assign last = (sel_i ? limit : limit_lo) + PRE_W'(mod_hi_i);
  assign tc_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (en_i) begin
      if (tc_o)           cnt_q <= '0;
      else                cnt_q <= cnt_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/psd_swallow_main.sv
module psd_swallow_main #(
  parameter int unsigned A_W = 7,
  parameter int unsigned N_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           pre_tc_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic [N_W-1:0] main_i,
  input  logic           sel_i,
  output logic           mod_hi_o,
  output logic           sel_o,
  output logic           running_o,
  output logic           term_o
);
  logic [A_W-1:0] sw_q;
  logic [N_W-1:0] n_q;
  logic           sel_q;
  logic           load;

  assign running_o = (n_q != '0);
  assign term_o    = pre_tc_i && (n_q == N_W'(1));
  assign load      = !running_o || term_o;
  assign mod_hi_o  = (sw_q != '0);
  assign sel_o     = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= '0;
      n_q   <= '0;
      sel_q <= 1'b0;
    end else if (clr_i) begin
      sw_q  <= '0;
      n_q   <= '0;
      sel_q <= 1'b0;
    end else if (load) begin
      // settings sampled only here, so a period is never cut short
      sw_q  <= swallow_i;
      n_q   <= main_i;
      sel_q <= sel_i;
    end else if (pre_tc_i) begin
      n_q <= n_q - N_W'(1);
      if (sw_q != '0) sw_q <= sw_q - A_W'(1);
    end
  end
endmodule

// File: rtl/psd_ref_counter.sv
module psd_ref_counter #(
  parameter int unsigned R_W = 14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [R_W-1:0] ref_i,
  output logic           tc_o
);
  logic [R_W-1:0] cnt_q;

  assign tc_o = (cnt_q == R_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (cnt_q == '0 || tc_o)   cnt_q <= ref_i;
    else                            cnt_q <= cnt_q - R_W'(1);
  end
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int unsigned A_W       = 7,
  parameter int unsigned N_W       = 11,
  parameter int unsigned R_W       = 14,
  parameter bit          HIGH_BAND = 1'b0
) (
  input  logic           clk_vco_i,
  input  logic           clk_osc_i,
  input  logic           rst_ni,
  input  logic           pwrsave_ni,
  input  logic [A_W-1:0] swallow_i,
  input  logic [N_W-1:0] main_i,
  input  logic [R_W-1:0] ref_i,
  input  logic           band_sel_i,
  output logic           fp_o,
  output logic           fr_o
);
  logic hold;
  logic pre_tc;
  logic mod_hi;
  logic sel_cur;
  logic running;
  logic term;
  logic ref_tc;
  logic fp_q;
  logic fr_q;

  assign hold = !pwrsave_ni;

  psd_prescaler #(.HIGH_BAND(HIGH_BAND)) u_pre (
    .clk_i    (clk_vco_i),
    .rst_ni   (rst_ni),
    .clr_i    (hold),
    .en_i     (running),
    .sel_i    (sel_cur),
    .mod_hi_i (mod_hi),
    .tc_o     (pre_tc)
  );

  psd_swallow_main #(.A_W(A_W), .N_W(N_W)) u_cnt (
    .clk_i     (clk_vco_i),
    .rst_ni    (rst_ni),
    .clr_i     (hold),
    .pre_tc_i  (pre_tc),
    .swallow_i (swallow_i),
    .main_i    (main_i),
    .sel_i     (band_sel_i),
    .mod_hi_o  (mod_hi),
    .sel_o     (sel_cur),
    .running_o (running),
    .term_o    (term)
  );

  psd_ref_counter #(.R_W(R_W)) u_ref (
    .clk_i  (clk_osc_i),
    .rst_ni (rst_ni),
    .clr_i  (hold),
    .ref_i  (ref_i),
    .tc_o   (ref_tc)
  );

  always_ff @(posedge clk_vco_i or negedge rst_ni) begin
    if (!rst_ni) fp_q <= 1'b0;
    else         fp_q <= pwrsave_ni && term;
  end

  always_ff @(posedge clk_osc_i or negedge rst_ni) begin
    if (!rst_ni) fr_q <= 1'b0;
    else         fr_q <= pwrsave_ni && ref_tc;
  end

  assign fp_o = fp_q;
  assign fr_o = fr_q;
endmodule

// File: rtl/psd_checker.sv
module psd_checker (
  input logic clk_vco_i,
  input logic clk_osc_i,
  input logic rst_ni,
  input logic pwrsave_ni,
  input logic fp_o,
  input logic fr_o,
  input logic pre_tc,
  input logic mod_hi,
  input logic running
);
  p_fp_single_r5: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  p_fr_single_r5: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    fr_o |=> !fr_o);

  p_fp_after_tc_r1: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    $rose(fp_o) |-> $past(pre_tc));

  p_mod_steady_r3: assert property (@(posedge clk_vco_i) disable iff (!rst_ni || !pwrsave_ni)
    (running && !pre_tc) |=> $stable(mod_hi));

  p_fp_quiet_r8: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    !pwrsave_ni |=> !fp_o);

  p_fr_quiet_r8: assert property (@(posedge clk_osc_i) disable iff (!rst_ni)
    !pwrsave_ni |=> !fr_o);
endmodule

bind pulse_swallow_divider psd_checker u_psd_checker (
  .clk_vco_i  (clk_vco_i),
  .clk_osc_i  (clk_osc_i),
  .rst_ni     (rst_ni),
  .pwrsave_ni (pwrsave_ni),
  .fp_o       (fp_o),
  .fr_o       (fr_o),
  .pre_tc     (pre_tc),
  .mod_hi     (mod_hi),
  .running    (running)
);

// File: tb/pulse_swallow_divider_bench.sv
`timescale 1ns/1ps
module pulse_swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ps_n = 1'b1;
  logic [6:0]  a = 7'd0, ah = 7'd0;
  logic [10:0] n = 11'd3, nh = 11'd3;
  logic [13:0] r = 14'd5;
  logic        sel = 1'b1, selh = 1'b1;
  logic        fp, fr, fp_h, fr_h;
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk_vco_i(clk), .clk_osc_i(clk), .rst_ni(rst_n), .pwrsave_ni(ps_n),
    .swallow_i(a), .main_i(n), .ref_i(r), .band_sel_i(sel),
    .fp_o(fp), .fr_o(fr));

  pulse_swallow_divider #(.HIGH_BAND(1'b1)) u_pulse_swallow_divider_hb (
    .clk_vco_i(clk), .clk_osc_i(clk), .rst_ni(rst_n), .pwrsave_ni(ps_n),
    .swallow_i(ah), .main_i(nh), .ref_i(r), .band_sel_i(selh),
    .fp_o(fp_h), .fr_o(fr_h));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per(input bit hb, input bit s, input int nn, input int aa);
    return (32 << (int'(hb) + int'(!s))) * nn + aa;
  endfunction

  // counts negedges until the chosen pulse is seen high
  task automatic wait_pulse(input int which, output int cnt);
    bit hit;
    cnt = 0;
    hit = 1'b0;
    while (!hit && cnt < 40000) begin
      @(negedge clk);
      cnt++;
      hit = (which == 0) ? fp : (which == 1) ? fr : fp_h;
    end
    if (!hit) chk(1'b0, "R1 pulse timeout", cnt, 0);
  endtask

  task automatic restart();
    @(negedge clk);
    ps_n = 1'b0;
    repeat (3) @(negedge clk);
    ps_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int c;
    int t;
    int seen;
    // R9: reset state and first pulse after release
    a = 7'd1; n = 11'd3; sel = 1'b1;
    repeat (3) @(negedge clk);
    chk(fp == 1'b0 && fr == 1'b0, "R9 outputs low in reset", int'(fp | fr), 0);
    rst_n = 1'b1;
    t = per(0, 1, 3, 1);
    wait_pulse(0, c);
    chk(c == t + 1, "R9 first fp after reset", c, t + 1);
    @(negedge clk);
    chk(fp == 1'b0, "R5 fp single cycle", int'(fp), 0);

    // R1 R3 R8: sweep small N and every legal A, P=32
    for (int nn = 3; nn <= 6; nn++) begin
      for (int aa = 0; aa < nn; aa++) begin
        a = 7'(aa); n = 11'(nn); sel = 1'b1;
        t = per(0, 1, nn, aa);
        restart();
        wait_pulse(0, c);
        chk(c == t + 1, "R8 first fp after power-save", c, t + 1);
        wait_pulse(0, c);
        chk(c == t, "R1 R3 fp period", c, t);
      end
    end

    // R2 R1: P=64 in low band, plus largest swallow
    for (int aa = 0; aa < 3; aa++) begin
      a = 7'(aa * 2); n = 11'd5; sel = 1'b0;
      t = per(0, 0, 5, aa * 2);
      restart();
      wait_pulse(0, c);
      wait_pulse(0, c);
      chk(c == t, "R2 low band select low period", c, t);
    end
    a = 7'd127; n = 11'd128; sel = 1'b1;
    t = per(0, 1, 128, 127);
    restart();
    wait_pulse(0, c);
    wait_pulse(0, c);
    chk(c == t, "R1 R3 max swallow period", c, t);

    // R2: high band instance, both selects
    for (int s = 0; s < 2; s++) begin
      for (int aa = 0; aa < 3; aa += 2) begin
        ah = 7'(aa); nh = 11'd3; selh = s[0];
        t = per(1, s[0], 3, aa);
        restart();
        wait_pulse(2, c);
        wait_pulse(2, c);
        chk(c == t, "R2 high band period", c, t);
      end
    end

    // R6: change just after a pulse; current period keeps old value
    a = 7'd2; n = 11'd4; sel = 1'b1;
    t = per(0, 1, 4, 2);
    restart();
    wait_pulse(0, c);
    a = 7'd5; n = 11'd7;
    wait_pulse(0, c);
    chk(c == t, "R6 period in progress unchanged", c, t);
    t = per(0, 1, 7, 5);
    wait_pulse(0, c);
    chk(c == t, "R6 new setting applies next period", c, t);

    // R7: change lands in the terminal cycle of the period
    repeat (t - 1) @(negedge clk);
    a = 7'd0; n = 11'd3;
    wait_pulse(0, c);
    chk(c == 1, "R7 pulse after terminal cycle", c, 1);
    t = per(0, 1, 3, 0);
    wait_pulse(0, c);
    chk(c == t, "R7 terminal-cycle setting taken", c, t);

    // R4: reference sweep
    for (int rr = 3; rr <= 10; rr++) begin
      r = 14'(rr);
      restart();
      wait_pulse(1, c);
      chk(c == rr + 1, "R8 first fr after power-save", c, rr + 1);
      wait_pulse(1, c);
      chk(c == rr, "R4 fr period", c, rr);
      @(negedge clk);
      chk(fr == 1'b0, "R5 fr single cycle", int'(fr), 0);
    end
    r = 14'd16383;
    restart();
    wait_pulse(1, c);
    wait_pulse(1, c);
    chk(c == 16383, "R4 max reference period", c, 16383);

    // R6 on reference
    r = 14'd7;
    restart();
    wait_pulse(1, c);
    r = 14'd11;
    wait_pulse(1, c);
    chk(c == 7, "R6 fr period in progress unchanged", c, 7);
    wait_pulse(1, c);
    chk(c == 11, "R6 fr new setting next period", c, 11);

    // R8: held quiet while power-save low
    @(negedge clk);
    ps_n = 1'b0;
    seen = 0;
    repeat (400) begin
      @(negedge clk);
      if (fp || fr || fp_h || fr_h) seen++;
    end
    chk(seen == 0, "R8 no pulses in power-save", seen, 0);
    ps_n = 1'b1;

    finish_run();
  end
endmodule